// File: doc/BRIEF.md
# Audio Port Control and Status Register

This block is the control and status word for one direction (transmit or receive) of a serial audio port. It gathers five event flags from the port's datapath, pairs each flag with its own interrupt enable, and drives a single interrupt line. It also carries the port's command bits: a run enable, a DMA request enable, a FIFO pointer reset and a software reset for the whole port.

Three of the flags are sticky. A single-cycle pulse from the datapath sets them, and software clears them by writing one to the flag's bit. The other two flags are live copies of the FIFO level signals. Software reaches the register through a one-word write strobe with data and a read bus that always shows the current contents.

When software drops the run enable, the port does not stop at once. The enable reads back as busy, and `port_en` stays high, until the datapath signals the end of the current frame.

Top module: `aport_csr`

## Requirements
- R1: The flags occupy bits 16 to 20 as word start, sync error, FIFO error, FIFO warning and FIFO watermark. Each flag's interrupt enable sits 8 bits lower (bits 8 to 12). The control bits are run enable (0), DMA enable (1), FIFO reset (2) and software reset (3), and every other bit reads zero. `irq` is high exactly when some flag and its own enable are both set.
- R2: A one-cycle pulse on `ev_word_start`, `ev_sync_err` or `ev_fifo_err` sets its sticky flag on that clock edge. Writing one to the flag's bit clears it. Writing zero to the bit leaves it unchanged.
- R3: If a set pulse arrives in the same cycle as a write that clears the same flag, the flag stays set.
- R4: Bit 19 always equals `fifo_warn` and bit 20 always equals `fifo_wmark`. Writes have no effect on either bit.
- R5: Writing one to bit 2 makes `fifo_ptr_rst` high for exactly the cycle after the write edge. Bit 2 always reads zero.
- R6: After bit 3 is written to one, `port_rst` is high and bit 3 reads one. While the bit is set, the sticky flags are cleared and ignore set pulses, `port_en` is low, and writes to the run enable are ignored. Writing zero to bit 3 releases the port.
- R7: `dma_req` equals the DMA enable (bit 1) ANDed with `fifo_wmark`.
- R8: Writing one to bit 0 raises `port_en` and bit 0 on the next edge. After a write of zero, both stay high until a `frame_end` pulse arrives while the enable is clear. A `frame_end` pulse while the enable is set has no effect.
- R9: After reset, every flag, enable and command bit reads zero, and `irq`, `dma_req`, `fifo_ptr_rst`, `port_rst` and `port_en` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Write strobe for the register word |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Current register contents |
| ev_word_start | input | 1 | Pulse: a word is starting |
| ev_sync_err | input | 1 | Pulse: frame sync arrived at the wrong time |
| ev_fifo_err | input | 1 | Pulse: FIFO underrun (transmit) or overflow (receive) |
| fifo_warn | input | 1 | Level: FIFO is empty (transmit) or full (receive) |
| fifo_wmark | input | 1 | Level: FIFO has crossed its watermark |
| frame_end | input | 1 | Pulse: the current frame has finished |
| irq | output | 1 | Interrupt request |
| dma_req | output | 1 | DMA request |
| fifo_ptr_rst | output | 1 | One-cycle FIFO pointer reset |
| port_rst | output | 1 | Holds the port datapath in reset |
| port_en | output | 1 | Port active, including the drain to the end of the frame |

## Verification
A wrong sticky bit shows at once on `reg_rdata` bits 16 to 18 on the edge after the pulse or the write, and on `irq` whenever its enable is set. This makes the tie between an event pulse and a clearing write, and the clears forced by software reset, visible within one cycle. A fault in the run/drain tracking shows as `port_en` and bit 0 dropping on a write of zero, or staying high after a frame-end pulse, on the following edge. The bench therefore keeps a reference model in step with the design and compares every output on every clock.

// File: rtl/aport_csr_pkg.sv
package aport_csr_pkg;

    // Control bit positions
    localparam int unsigned BIT_RUN     = 0;
    localparam int unsigned BIT_DMAEN   = 1;
    localparam int unsigned BIT_FIFORST = 2;
    localparam int unsigned BIT_SWRST   = 3;

    // Flag and enable fields
    localparam int unsigned N_FLAG    = 5;
    localparam int unsigned N_STICKY  = 3;
    localparam int unsigned IE_LSB    = 8;
    localparam int unsigned FLAG_LSB  = 16;
    localparam int unsigned IE_SHIFT  = FLAG_LSB - IE_LSB;
    localparam int unsigned FIELD_TOP = FLAG_LSB + N_FLAG;

    // Flag indices inside the flag field
    localparam int unsigned F_WSTART  = 0;
    localparam int unsigned F_SYNCERR = 1;
    localparam int unsigned F_FIFOERR = 2;
    localparam int unsigned F_WARN    = 3;
    localparam int unsigned F_WMARK   = 4;

    typedef enum logic [1:0] {
        PORT_IDLE  = 2'd0,
        PORT_RUN   = 2'd1,
        PORT_DRAIN = 2'd2
    } port_state_e;

    typedef struct packed {
        logic              swrst;
        logic              dma_en;
        logic [N_FLAG-1:0] ie;
    } ctl_t;

    function automatic logic [FIELD_TOP-1:0] pack_word(
        input ctl_t              c,
        input logic [N_FLAG-1:0] flags,
        input logic              busy
    );
        logic [FIELD_TOP-1:0] w;
        w                       = '0;
        w[BIT_RUN]              = busy;
        w[BIT_DMAEN]            = c.dma_en;
        w[BIT_SWRST]            = c.swrst;
        w[IE_LSB +: N_FLAG]     = c.ie;
        w[FLAG_LSB +: N_FLAG]   = flags;
        return w;
    endfunction

endpackage

// File: rtl/aport_sticky_flags.sv
module aport_sticky_flags #(
    parameter int unsigned N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         hold,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flags_o
);

    for (genvar i = 0; i < N; i++) begin : g_flag
        logic q;
        always_ff @(posedge clk) begin
            if (rst || hold) begin
                q <= 1'b0;
            end else if (set_i[i]) begin
                q <= 1'b1;          // event beats a clear in the same cycle
            end else if (clr_i[i]) begin
                q <= 1'b0;
            end
        end
        assign flags_o[i] = q;
    end

endmodule

// File: rtl/aport_enable_ctl.sv
module aport_enable_ctl
    import aport_csr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic hold,
    input  logic wr_i,
    input  logic run_i,
    input  logic frame_end_i,
    output logic busy_o
);

    port_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PORT_IDLE: begin
                if (wr_i && run_i) state_d = PORT_RUN;
            end
            PORT_RUN: begin
                if (wr_i && !run_i) state_d = PORT_DRAIN;
            end
            PORT_DRAIN: begin
                if (wr_i && run_i)    state_d = PORT_RUN;
                else if (frame_end_i) state_d = PORT_IDLE;
            end
            default: state_d = PORT_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || hold) state_q <= PORT_IDLE;
        else             state_q <= state_d;
    end

    assign busy_o = (state_q != PORT_IDLE);

endmodule

// File: rtl/aport_event_out.sv
module aport_event_out #(
    parameter int unsigned N         = 5,
    parameter int unsigned WMARK_IDX = 4
) (
    input  logic [N-1:0] flags_i,
    input  logic [N-1:0] ie_i,
    input  logic         dma_en_i,
    output logic         irq_o,
    output logic         dma_req_o
);

    assign irq_o     = |(flags_i & ie_i);
    assign dma_req_o = dma_en_i & flags_i[WMARK_IDX];

endmodule

// File: rtl/aport_csr.sv
module aport_csr
    import aport_csr_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              ev_word_start,
    input  logic              ev_sync_err,
    input  logic              ev_fifo_err,
    input  logic              fifo_warn,
    input  logic              fifo_wmark,
    input  logic              frame_end,
    output logic              irq,
    output logic              dma_req,
    output logic              fifo_ptr_rst,
    output logic              port_rst,
    output logic              port_en
);

    localparam int unsigned PAD_W = DATA_W - FIELD_TOP;

    ctl_t                ctl_q;
    logic                ptr_q;
    logic [N_STICKY-1:0] sticky_set;
    logic [N_STICKY-1:0] sticky_clr;
    logic [N_STICKY-1:0] sticky_q;
    logic [N_FLAG-1:0]   flags;
    logic                busy;
    logic                unused_wbits;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
            ptr_q <= 1'b0;
        end else begin
            ptr_q <= reg_wr && reg_wdata[BIT_FIFORST];
            if (reg_wr) begin
                ctl_q.swrst  <= reg_wdata[BIT_SWRST];
                ctl_q.dma_en <= reg_wdata[BIT_DMAEN];
                ctl_q.ie     <= reg_wdata[IE_LSB +: N_FLAG];
            end
        end
    end

    assign sticky_set[F_WSTART]  = ev_word_start;
    assign sticky_set[F_SYNCERR] = ev_sync_err;
    assign sticky_set[F_FIFOERR] = ev_fifo_err;
    assign sticky_clr = reg_wr ? reg_wdata[FLAG_LSB +: N_STICKY] : '0;

    aport_sticky_flags #(.N(N_STICKY)) u_sticky (
        .clk     (clk),
        .rst     (rst),
        .hold    (ctl_q.swrst),
        .set_i   (sticky_set),
        .clr_i   (sticky_clr),
        .flags_o (sticky_q)
    );

    aport_enable_ctl u_enable (
        .clk         (clk),
        .rst         (rst),
        .hold        (ctl_q.swrst),
        .wr_i        (reg_wr),
        .run_i       (reg_wdata[BIT_RUN]),
        .frame_end_i (frame_end),
        .busy_o      (busy)
    );

    assign flags = {fifo_wmark, fifo_warn, sticky_q};

    aport_event_out #(.N(N_FLAG), .WMARK_IDX(F_WMARK)) u_out (
        .flags_i   (flags),
        .ie_i      (ctl_q.ie),
        .dma_en_i  (ctl_q.dma_en),
        .irq_o     (irq),
        .dma_req_o (dma_req)
    );

    assign reg_rdata    = {{PAD_W{1'b0}}, pack_word(ctl_q, flags, busy)};
    assign fifo_ptr_rst = ptr_q;
    assign port_rst     = ctl_q.swrst;
    assign port_en      = busy;
    assign unused_wbits = ^reg_wdata;

endmodule

// File: rtl/aport_csr_chk.sv
module aport_csr_chk
    import aport_csr_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              reg_wr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [DATA_W-1:0] reg_rdata,
    input logic              ev_word_start,
    input logic              fifo_warn,
    input logic              fifo_wmark,
    input logic              frame_end,
    input logic              irq,
    input logic              dma_req,
    input logic              fifo_ptr_rst,
    input logic              port_rst,
    input logic              port_en
);

    // R1: interrupt is the OR of each flag with the enable 8 bits below it
    p_irq_align_r1: assert property (@(posedge clk) disable iff (rst)
        irq == |(reg_rdata[FLAG_LSB +: N_FLAG] & reg_rdata[IE_LSB +: N_FLAG]));

    // R2: a clearing write with no event clears the word-start flag
    p_clear_r2: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_wdata[FLAG_LSB + F_WSTART] && !ev_word_start && !port_rst)
        |=> !reg_rdata[FLAG_LSB + F_WSTART]);

    // R3: an event always lands, even against a clear
    p_event_wins_r3: assert property (@(posedge clk) disable iff (rst)
        (ev_word_start && !port_rst) |=> reg_rdata[FLAG_LSB + F_WSTART]);

    // R4: warning flag is the live input
    p_live_warn_r4: assert property (@(posedge clk) disable iff (rst)
        reg_rdata[FLAG_LSB + F_WARN] == fifo_warn);

    // R5: pointer reset follows a write of one to its bit
    p_ptr_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_wdata[BIT_FIFORST]) |=> fifo_ptr_rst);

    p_ptr_cause_r5: assert property (@(posedge clk) disable iff (rst)
        fifo_ptr_rst |-> $past(reg_wr && reg_wdata[BIT_FIFORST]));

    // R6: a held software reset keeps the port stopped and the flags clear
    p_srst_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (port_rst && $past(port_rst))
        |-> (!port_en && reg_rdata[FLAG_LSB +: N_STICKY] == '0));

    // R7: DMA request gated by its enable
    p_dma_gate_r7: assert property (@(posedge clk) disable iff (rst)
        dma_req == (reg_rdata[BIT_DMAEN] && fifo_wmark));

    // R8: enabling starts the port; it only stops at a frame end or a reset
    p_en_set_r8: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_wdata[BIT_RUN] && !port_rst) |=> port_en);

    p_busy_drop_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(port_en) |-> ($past(frame_end) || $past(port_rst)));

endmodule

bind aport_csr aport_csr_chk #(.DATA_W(DATA_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .reg_wr        (reg_wr),
    .reg_wdata     (reg_wdata),
    .reg_rdata     (reg_rdata),
    .ev_word_start (ev_word_start),
    .fifo_warn     (fifo_warn),
    .fifo_wmark    (fifo_wmark),
    .frame_end     (frame_end),
    .irq           (irq),
    .dma_req       (dma_req),
    .fifo_ptr_rst  (fifo_ptr_rst),
    .port_rst      (port_rst),
    .port_en       (port_en)
);

// File: tb/aport_csr_tb.sv
`timescale 1ns/1ps
module aport_csr_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic        ev_word_start = 1'b0, ev_sync_err = 1'b0, ev_fifo_err = 1'b0;
    logic        fifo_warn = 1'b0, fifo_wmark = 1'b0, frame_end = 1'b0;
    logic [31:0] reg_rdata;
    logic        irq, dma_req, fifo_ptr_rst, port_rst, port_en;

    always #2 clk = ~clk;   // 250 MHz

    aport_csr u_dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .ev_word_start(ev_word_start),
        .ev_sync_err(ev_sync_err), .ev_fifo_err(ev_fifo_err),
        .fifo_warn(fifo_warn), .fifo_wmark(fifo_wmark), .frame_end(frame_end),
        .irq(irq), .dma_req(dma_req), .fifo_ptr_rst(fifo_ptr_rst),
        .port_rst(port_rst), .port_en(port_en)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Behavioural reference model
    bit       m_run, m_busy, m_dma, m_srst, m_ptr;
    bit [4:0] m_ie;
    bit [2:0] m_st;

    always @(posedge clk) begin
        if (rst) begin
            m_run = 0; m_busy = 0; m_dma = 0; m_srst = 0; m_ptr = 0;
            m_ie = 0; m_st = 0;
        end else begin
            bit       n_run, n_busy;
            bit [2:0] n_st, ev, clr;
            ev  = {ev_fifo_err, ev_sync_err, ev_word_start};
            clr = reg_wr ? reg_wdata[18:16] : 3'b000;
            if (m_srst) begin
                n_st = 0; n_run = 0; n_busy = 0;
            end else begin
                n_st  = (m_st & ~clr) | ev;
                n_run = reg_wr ? reg_wdata[0] : m_run;
                if (reg_wr && reg_wdata[0])   n_busy = 1;
                else if (frame_end && !m_run) n_busy = 0;
                else                          n_busy = m_busy;
            end
            m_ptr = reg_wr && reg_wdata[2];
            if (reg_wr) begin
                m_srst = reg_wdata[3];
                m_dma  = reg_wdata[1];
                m_ie   = reg_wdata[12:8];
            end
            m_st = n_st; m_run = n_run; m_busy = n_busy;
        end
    end

    function automatic logic [31:0] exp_word();
        return {11'b0, fifo_wmark, fifo_warn, m_st, 3'b0, m_ie, 4'b0,
                m_srst, 1'b0, m_dma, m_busy};
    endfunction

    always @(negedge clk) begin
        if (!rst && !finished) begin
            chk("R1 readback", reg_rdata, exp_word());
            chk("R1 irq", {31'b0, irq}, {31'b0, |({fifo_wmark, fifo_warn, m_st} & m_ie)});
            chk("R7 dma_req", {31'b0, dma_req}, {31'b0, m_dma & fifo_wmark});
            chk("R5 fifo_ptr_rst", {31'b0, fifo_ptr_rst}, {31'b0, m_ptr});
            chk("R6 port_rst", {31'b0, port_rst}, {31'b0, m_srst});
            chk("R8 port_en", {31'b0, port_en}, {31'b0, m_busy});
        end
    end

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic write(input logic [31:0] v);
        cyc(); reg_wr = 1'b1; reg_wdata = v;
        cyc(); reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic pulse(input int which);
        cyc();
        case (which)
            0: ev_word_start = 1'b1;
            1: ev_sync_err   = 1'b1;
            2: ev_fifo_err   = 1'b1;
            default: frame_end = 1'b1;
        endcase
        cyc();
        ev_word_start = 1'b0; ev_sync_err = 1'b0; ev_fifo_err = 1'b0; frame_end = 1'b0;
    endtask

    localparam logic [31:0] IE_ALL = 32'h0000_1F00;

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
            summary();
            $finish;
        end
    end

    initial begin
        repeat (4) cyc();
        @(negedge clk);
        chk("R9 rdata in reset", reg_rdata, 32'h0);
        cyc(); rst = 1'b0;
        @(negedge clk);
        chk("R9 rdata after reset", reg_rdata, 32'h0);
        chk("R9 outputs after reset",
            {27'b0, irq, dma_req, fifo_ptr_rst, port_rst, port_en}, 32'h0);

        // R2: sticky set, write zero keeps, write one clears
        write(IE_ALL);
        pulse(0);
        @(negedge clk);
        chk("R2 word start set", {31'b0, reg_rdata[16]}, 32'd1);
        chk("R1 irq on enabled flag", {31'b0, irq}, 32'd1);
        write(IE_ALL);
        @(negedge clk);
        chk("R2 write zero keeps flag", {31'b0, reg_rdata[16]}, 32'd1);
        write(IE_ALL | 32'h0001_0000);
        @(negedge clk);
        chk("R2 write one clears", {31'b0, reg_rdata[16]}, 32'd0);
        chk("R1 irq drops", {31'b0, irq}, 32'd0);

        // R3: event and clear in the same cycle
        cyc(); ev_sync_err = 1'b1; reg_wr = 1'b1; reg_wdata = IE_ALL | 32'h0002_0000;
        cyc(); ev_sync_err = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
        @(negedge clk);
        chk("R3 event beats clear", {31'b0, reg_rdata[17]}, 32'd1);
        write(IE_ALL | 32'h0002_0000);
        @(negedge clk);
        chk("R3 later clear works", {31'b0, reg_rdata[17]}, 32'd0);

        // R1: enable alignment
        write(32'h0);
        pulse(2);
        @(negedge clk);
        chk("R1 flag without enable", {30'b0, reg_rdata[18], irq}, 32'd2);
        write(32'h0000_0400);
        @(negedge clk);
        chk("R1 enable at bit 10 raises irq", {31'b0, irq}, 32'd1);
        write(32'h0004_0000);
        @(negedge clk);
        chk("R1 cleared, irq low", {30'b0, reg_rdata[18], irq}, 32'd0);

        // R4: live warning flag
        cyc(); fifo_warn = 1'b1;
        @(negedge clk);
        chk("R4 warning mirrors input", {31'b0, reg_rdata[19]}, 32'd1);
        write(32'h0008_0000);
        @(negedge clk);
        chk("R4 write does not clear", {31'b0, reg_rdata[19]}, 32'd1);
        cyc(); fifo_warn = 1'b0;
        @(negedge clk);
        chk("R4 warning follows input low", {31'b0, reg_rdata[19]}, 32'd0);

        // R7: DMA gating
        cyc(); fifo_wmark = 1'b1;
        @(negedge clk);
        chk("R7 no dma while disabled", {31'b0, dma_req}, 32'd0);
        write(32'h0000_0002);
        @(negedge clk);
        chk("R7 dma with enable", {30'b0, dma_req, reg_rdata[20]}, 32'd3);
        cyc(); fifo_wmark = 1'b0;
        @(negedge clk);
        chk("R7 dma follows watermark", {31'b0, dma_req}, 32'd0);

        // R5: FIFO pointer reset pulse
        write(32'h0000_0004);
        @(negedge clk);
        chk("R5 pulse after write", {30'b0, fifo_ptr_rst, reg_rdata[2]}, 32'd2);
        cyc();
        @(negedge clk);
        chk("R5 pulse is one cycle", {31'b0, fifo_ptr_rst}, 32'd0);

        // R8: run, drain, stop at frame end
        write(32'h0000_0001);
        @(negedge clk);
        chk("R8 port enabled", {30'b0, port_en, reg_rdata[0]}, 32'd3);
        pulse(3);
        @(negedge clk);
        chk("R8 frame end while running ignored", {31'b0, port_en}, 32'd1);
        write(32'h0);
        repeat (3) cyc();
        @(negedge clk);
        chk("R8 busy until frame end", {30'b0, port_en, reg_rdata[0]}, 32'd3);
        pulse(3);
        @(negedge clk);
        chk("R8 stops at frame end", {30'b0, port_en, reg_rdata[0]}, 32'd0);

        // R6: software reset
        write(32'h0000_0001);
        pulse(0);
        write(32'h0000_0008);
        cyc();
        @(negedge clk);
        chk("R6 port_rst and bit 3", {30'b0, port_rst, reg_rdata[3]}, 32'd3);
        chk("R6 flags and enable cleared", {30'b0, reg_rdata[16], port_en}, 32'd0);
        pulse(0);
        @(negedge clk);
        chk("R6 events ignored in reset", {31'b0, reg_rdata[16]}, 32'd0);
        write(32'h0000_0009);
        @(negedge clk);
        chk("R6 enable ignored in reset", {31'b0, port_en}, 32'd0);
        write(32'h0);
        pulse(0);
        @(negedge clk);
        chk("R6 released", {30'b0, port_rst, reg_rdata[16]}, 32'd1);

        repeat (2) cyc();
        finished = 1;
        summary();
        $finish;
    end

endmodule